// File: doc/BRIEF.md
# Sequential Particle Stream Controller

This block sits between the processing stages of a particle-based estimator and a burst-oriented external memory. A stage never sees an address. It pulses `start` with a direction and a region, then either pushes N particle records or pulls N particle records, always in index order from 0 to N-1. Each record is one 128-bit beat. The memory moves four beats per request. Burst addresses are counted inside the controller, and the count goes back to zero at every accepted start.

In a read stage the controller asks the memory for bursts before the consumer wants them. The returned beats wait in a small local FIFO, so data is presented as soon as the consumer is ready. Read requests are held back whenever the FIFO could not take a whole burst. In a write stage the incoming records are gathered four at a time into one wide write request. If N is not a multiple of four, the last request is filled with zero beats, and on the way back those filler beats are dropped before they reach the FIFO.

Three regions share the memory: a main region for quaternion-form particles and two auxiliary regions for the Euler-form copies used by the correction path. Each region occupies ceil(N/4) consecutive burst addresses.

Top module: `particle_stream_ctrl`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `memReq`, `rdValid` and `wrReady` are all 0.
- R2: A start pulse accepted while idle latches `writeMode` (1 = write stage, 0 = read stage) and `regionSel` (0 = main, 1 = first auxiliary, 2 = second auxiliary, 3 = same as main). Changes on these inputs later in the stage have no effect on the stage.
- R3: Burst k of a stage in region r is requested at `memAddr` = r*ceil(N/4) + k. Bursts go out for k = 0, 1, ... in increasing order, each once, and exactly ceil(N/4) bursts are issued per stage.
- R4: In a read stage, bursts are requested without waiting for the consumer. Beats held in the FIFO plus beats still owed by memory never exceed FIFO_DEPTH. With the consumer stalled from the start of the stage, exactly FIFO_DEPTH/4 bursts are requested, and `rdValid` is 1.
- R5: A read stage presents exactly N records on `rdData`, in index order, and one record moves on each cycle where `rdValid` and `rdReady` are both 1. Filler beats (index N and above) never appear.
- R6: A write request carries record 4k+j at `memWdata[j*128 +: 128]`. Beats of the final burst beyond index N-1 are zero.
- R7: `wrReady` is 0 while a full burst waits for `memReqReady`, and it is 0 once N records have been accepted in the stage.
- R8: `busy` is 1 during a stage. `done` rises when the stage completes and stays 1 until the next accepted start. A read stage completes after N records are consumed and all requested beats have returned. A write stage completes when its last burst is accepted.
- R9: A start pulse while `busy` is 1 is ignored.
- R10: While `memReq` is 1 and `memReqReady` is 0, `memReq`, `memWrite` and `memAddr` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a stage (ignored while busy) |
| writeMode | input | 1 | Stage direction sampled at start: 1 write, 0 read |
| regionSel | input | 2 | Region sampled at start |
| busy | output | 1 | Stage in progress |
| done | output | 1 | Last stage finished; cleared by next start |
| rdValid | output | 1 | Record available on rdData |
| rdReady | input | 1 | Consumer takes the record |
| rdData | output | 128 | Record to consumer |
| wrValid | input | 1 | Producer offers a record |
| wrReady | output | 1 | Controller accepts the record |
| wrData | input | 128 | Record from producer |
| memReq | output | 1 | Burst request to memory |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 16 | Burst address |
| memWdata | output | 512 | Four write beats, beat j in bits j*128 upward |
| memReqReady | input | 1 | Memory accepts the request |
| memRvalid | input | 1 | One read beat returned |
| memRdata | input | 128 | Returned read beat |

## Verification
The hardest situation to reach is a full FIFO with reads still owed by memory. Prefetch has to stop there, yet the stage must still finish once the consumer resumes. The bench starts a read stage with the consumer held off for dozens of cycles. It counts the burst requests the controller makes in that window, then releases the consumer and checks every record in order. Filler beats of a partial last burst and a stalled write request are reached by choosing N = 10 and by holding `memReqReady` low during a write stage.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } pscState_e;

  // strobes from the control section to the datapath
  typedef struct packed {
    logic flush;      // new stage: empty FIFO and pack register
    logic push;       // store returned beat into FIFO
    logic pop;        // consumer takes FIFO head
    logic packLoad;   // place write record into pack slot
    logic packClear;  // burst accepted: zero pack register
  } pscStrobe_t;

endpackage

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int BEAT_W     = 128,
  parameter int BURST_LEN  = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pscStrobe_t                  strobe,
  input  logic [$clog2(BURST_LEN)-1:0] packSlot,
  input  logic [BEAT_W-1:0]           memRdata,
  input  logic [BEAT_W-1:0]           wrData,
  output logic [BEAT_W-1:0]           rdData,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifoCount,
  output logic [BURST_LEN*BEAT_W-1:0] packData
);

  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int SLOT_W = $clog2(BURST_LEN);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [BEAT_W-1:0] store [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= stepPtr(wrPtr);
      if (strobe.pop)  rdPtr <= stepPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= memRdata;
  end

  assign rdData    = store[rdPtr];
  assign fifoCount = count;

  // write packing: one register per beat slot of a burst
  logic [BURST_LEN-1:0][BEAT_W-1:0] packReg;

  for (genvar g = 0; g < BURST_LEN; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN || strobe.flush || strobe.packClear) begin
        packReg[g] <= '0;
      end else if (strobe.packLoad && packSlot == SLOT_W'(g)) begin
        packReg[g] <= wrData;
      end
    end
  end

  assign packData = packReg;

  // R4: a returned beat is never written into a full FIFO
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop) |-> (count < CNT_W'(FIFO_DEPTH)));

  // R5: consumer never takes from an empty FIFO
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (count != '0));

endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int N_PART     = 10,
  parameter int BURST_LEN  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            start,
  input  logic                            writeMode,
  input  logic [1:0]                      regionSel,
  output logic                            busy,
  output logic                            done,
  output logic                            rdValid,
  input  logic                            rdReady,
  input  logic                            wrValid,
  output logic                            wrReady,
  output logic                            memReq,
  output logic                            memWrite,
  output logic [ADDR_W-1:0]               memAddr,
  input  logic                            memReqReady,
  input  logic                            memRvalid,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifoCount,
  output pscStrobe_t                      strobe,
  output logic [$clog2(BURST_LEN)-1:0]    packSlot
);

  localparam int NUM_BURSTS = (N_PART + BURST_LEN - 1) / BURST_LEN;
  localparam int PCW    = $clog2(N_PART + 1);
  localparam int BCW    = $clog2(NUM_BURSTS + 1);
  localparam int RCW    = $clog2(NUM_BURSTS * BURST_LEN + 1);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int SUM_W  = CNT_W + 2;
  localparam int SLOT_W = $clog2(BURST_LEN);

  pscState_e         state;
  logic [ADDR_W-1:0] baseQ;
  logic [BCW-1:0]    issued;
  logic [PCW-1:0]    moved;
  logic [RCW-1:0]    retIdx;
  logic [CNT_W-1:0]  inflight;
  logic [SLOT_W-1:0] beatIdx;
  logic              burstPending;
  logic              doneQ;

  logic              startOk;
  logic [ADDR_W-1:0] regionBase;
  logic              moreBursts, room, readReq, writeReq, reqFire;
  logic              keepBeat, popFire, wrFire;
  logic              lastAccept, lastSlot, readDone, writeLast;
  logic [SUM_W-1:0]  reserved;
  logic [CNT_W-1:0]  inflightNext;

  assign startOk = start && (state == ST_IDLE);

  always_comb begin
    case (regionSel)
      2'd1:    regionBase = ADDR_W'(NUM_BURSTS);
      2'd2:    regionBase = ADDR_W'(2 * NUM_BURSTS);
      default: regionBase = '0;
    endcase
  end

  // prefetch admission: owed beats plus stored beats must leave a burst free
  assign moreBursts = issued < BCW'(NUM_BURSTS);
  assign reserved   = SUM_W'(fifoCount) + SUM_W'(inflight);
  assign room       = (reserved + SUM_W'(BURST_LEN)) <= SUM_W'(FIFO_DEPTH);
  assign readReq    = (state == ST_READ) && moreBursts && room;
  assign writeReq   = (state == ST_WRITE) && burstPending;

  assign memReq   = readReq || writeReq;
  assign memWrite = (state == ST_WRITE);
  assign memAddr  = baseQ + ADDR_W'(issued);
  assign reqFire  = memReq && memReqReady;

  assign keepBeat = memRvalid && (state == ST_READ) && (retIdx < RCW'(N_PART));
  assign rdValid  = (state == ST_READ) && (fifoCount != '0);
  assign popFire  = rdValid && rdReady;

  assign wrReady  = (state == ST_WRITE) && !burstPending && (moved < PCW'(N_PART));
  assign wrFire   = wrValid && wrReady;

  assign lastAccept = moved == PCW'(N_PART - 1);
  assign lastSlot   = beatIdx == SLOT_W'(BURST_LEN - 1);
  assign readDone   = (state == ST_READ) && (moved == PCW'(N_PART)) && (inflight == '0);
  assign writeLast  = writeReq && memReqReady && (issued == BCW'(NUM_BURSTS - 1));

  always_comb begin
    inflightNext = inflight;
    if (readReq && memReqReady) inflightNext = inflightNext + CNT_W'(BURST_LEN);
    if (memRvalid && state == ST_READ) inflightNext = inflightNext - CNT_W'(1);
  end

  always_comb begin
    strobe.flush     = startOk;
    strobe.push      = keepBeat;
    strobe.pop       = popFire;
    strobe.packLoad  = wrFire;
    strobe.packClear = writeReq && memReqReady;
  end
  assign packSlot = beatIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      baseQ        <= '0;
      issued       <= '0;
      moved        <= '0;
      retIdx       <= '0;
      inflight     <= '0;
      beatIdx      <= '0;
      burstPending <= 1'b0;
      doneQ        <= 1'b0;
    end else if (startOk) begin
      state        <= writeMode ? ST_WRITE : ST_READ;
      baseQ        <= regionBase;
      issued       <= '0;
      moved        <= '0;
      retIdx       <= '0;
      inflight     <= '0;
      beatIdx      <= '0;
      burstPending <= 1'b0;
      doneQ        <= 1'b0;
    end else begin
      case (state)
        ST_READ: begin
          if (reqFire)   issued <= issued + BCW'(1);
          if (memRvalid) retIdx <= retIdx + RCW'(1);
          inflight <= inflightNext;
          if (popFire)   moved <= moved + PCW'(1);
          if (readDone) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        ST_WRITE: begin
          if (wrFire) begin
            moved   <= moved + PCW'(1);
            beatIdx <= lastSlot ? '0 : beatIdx + SLOT_W'(1);
            if (lastSlot || lastAccept) burstPending <= 1'b1;
          end
          if (reqFire) begin
            burstPending <= 1'b0;
            beatIdx      <= '0;
            issued       <= issued + BCW'(1);
          end
          if (writeLast) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R10: an unaccepted request is held with the same address and kind
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReqReady) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  // R3: never more than ceil(N/4) bursts in a stage
  a_r3_burst_bound: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (issued < BCW'(NUM_BURSTS)));

  // R8: done is only shown when no stage runs
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2: region base stays fixed for the whole stage
  a_r2_region_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(baseQ));

  // R4: memory only returns beats that were requested
  a_r4_beats_owed: assert property (@(posedge clk) disable iff (!rstN)
    memRvalid |-> (inflight != '0));

endmodule

// File: rtl/particle_stream_ctrl.sv
module particle_stream_ctrl
  import psc_pkg::*;
#(
  parameter int N_PART     = 10,
  parameter int BEAT_W     = 128,
  parameter int BURST_LEN  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        writeMode,
  input  logic [1:0]                  regionSel,
  output logic                        busy,
  output logic                        done,
  output logic                        rdValid,
  input  logic                        rdReady,
  output logic [BEAT_W-1:0]           rdData,
  input  logic                        wrValid,
  output logic                        wrReady,
  input  logic [BEAT_W-1:0]           wrData,
  output logic                        memReq,
  output logic                        memWrite,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [BURST_LEN*BEAT_W-1:0] memWdata,
  input  logic                        memReqReady,
  input  logic                        memRvalid,
  input  logic [BEAT_W-1:0]           memRdata
);

  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int SLOT_W = $clog2(BURST_LEN);

  pscStrobe_t        strobe;
  logic [SLOT_W-1:0] packSlot;
  logic [CNT_W-1:0]  fifoCount;

  psc_ctrl #(
    .N_PART(N_PART), .BURST_LEN(BURST_LEN),
    .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .writeMode(writeMode),
    .regionSel(regionSel), .busy(busy), .done(done),
    .rdValid(rdValid), .rdReady(rdReady), .wrValid(wrValid), .wrReady(wrReady),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memReqReady(memReqReady), .memRvalid(memRvalid),
    .fifoCount(fifoCount), .strobe(strobe), .packSlot(packSlot)
  );

  psc_datapath #(
    .BEAT_W(BEAT_W), .BURST_LEN(BURST_LEN), .FIFO_DEPTH(FIFO_DEPTH)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .packSlot(packSlot),
    .memRdata(memRdata), .wrData(wrData), .rdData(rdData),
    .fifoCount(fifoCount), .packData(memWdata)
  );

endmodule

// File: tb/tb_particle_stream_ctrl.sv
`timescale 1ns/1ps
module tb_particle_stream_ctrl;

  localparam int N = 10, W = 128, BL = 4, DEPTH = 8, AW = 16;
  localparam int NB = (N + BL - 1) / BL;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, writeMode = 1'b0;
  logic [1:0] regionSel = 2'd0;
  logic busy, done, rdValid, rdReady, wrValid, wrReady;
  logic [W-1:0] rdData, wrData, memRdata;
  logic memReq, memWrite, memReqReady, memRvalid;
  logic [AW-1:0] memAddr;
  logic [BL*W-1:0] memWdata;

  always #2.5 clk = ~clk;

  particle_stream_ctrl #(.N_PART(N), .BEAT_W(W), .BURST_LEN(BL),
    .FIFO_DEPTH(DEPTH), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .writeMode(writeMode),
    .regionSel(regionSel), .busy(busy), .done(done),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReqReady(memReqReady),
    .memRvalid(memRvalid), .memRdata(memRdata));

  int checks = 0, failures = 0;
  bit ended = 0;
  int cyc = 0, readyMode = 1, consMode = 1;
  int curRegion = 0, stageBase = 0, expAddrNext = 0;
  int rdReqCount = 0, wrReqCount = 0;
  int rdQ[$];
  logic [W-1:0] expQ[$];
  logic [W-1:0] shadow [0:2][0:N-1];
  logic [W-1:0] mem [0:3*NB*BL-1];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] pval(input int r, input int i, input int tag);
    return {32'(tag), 32'(r), 32'(i), 32'hF00D_0000 ^ 32'(i * 7)};
  endfunction

  // input drivers for handshake readiness
  always @(posedge clk) begin
    cyc++;
    #1;
    memReqReady = (readyMode == 1) || (readyMode == 2 && cyc[0]);
    rdReady     = (consMode == 1) || (consMode == 2 && (cyc % 3 != 0));
  end

  // memory responder: one beat per cycle after a gap cycle per burst
  initial begin
    int rspAddr = 0, rspLeft = 0;
    memRvalid = 1'b0;
    memRdata = '0;
    forever begin
      @(posedge clk);
      #1;
      memRvalid = 1'b0;
      if (rspLeft > 0) begin
        memRvalid = 1'b1;
        memRdata = mem[rspAddr * BL + (BL - rspLeft)];
        rspLeft--;
      end else if (rdQ.size() > 0) begin
        rspAddr = rdQ.pop_front();
        rspLeft = BL;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memReqReady) begin
        chk(int'(memAddr) == expAddrNext, "R3 burst address", W'(memAddr), W'(expAddrNext));
        expAddrNext++;
        if (memWrite) begin
          wrReqCount++;
          for (int j = 0; j < BL; j++) begin
            int idx;
            logic [W-1:0] beat;
            idx = (int'(memAddr) - stageBase) * BL + j;
            beat = memWdata[j*W +: W];
            if (int'(memAddr) < 3 * NB) mem[int'(memAddr) * BL + j] = beat;
            if (idx >= N) chk(beat == '0, "R6 filler beat zero", beat, '0);
            else if (idx >= 0) chk(beat == shadow[curRegion][idx], "R6 beat placement", beat, shadow[curRegion][idx]);
          end
        end else begin
          rdReqCount++;
          rdQ.push_back(int'(memAddr));
        end
      end
      if (rdValid && rdReady) begin
        if (expQ.size() == 0) chk(1'b0, "R5 extra record", rdData, '0);
        else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          chk(rdData == e, "R5 record order", rdData, e);
        end
      end
    end
  end

  task automatic startStage(input bit wr, input int region);
    start = 1'b1;
    writeMode = wr;
    regionSel = 2'(region);
    curRegion = (region == 3) ? 0 : region;
    stageBase = curRegion * NB;
    expAddrNext = stageBase;
    rdReqCount = 0;
    wrReqCount = 0;
    @(posedge clk); #1;
    start = 1'b0;
    regionSel = ~2'(region);
    writeMode = !wr;
  endtask

  task automatic sendBeat(input logic [W-1:0] d);
    wrValid = 1'b1;
    wrData = d;
    @(negedge clk);
    while (!wrReady) @(negedge clk);
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 3000) begin
      @(posedge clk); #1;
      n++;
    end
    chk(done == 1'b1, "R8 done raised", W'(done), 1);
    chk(busy == 1'b0, "R8 busy cleared", W'(busy), 0);
  endtask

  task automatic readStage(input int region, input int cm);
    int eff;
    eff = (region == 3) ? 0 : region;
    for (int i = 0; i < N; i++) expQ.push_back(shadow[eff][i]);
    consMode = cm;
    startStage(1'b0, region);
    waitDone();
    chk(expQ.size() == 0, "R5 all records delivered", W'(expQ.size()), 0);
    chk(rdReqCount == NB, "R3 read burst count", W'(rdReqCount), W'(NB));
    @(negedge clk);
    chk(rdValid == 1'b0, "R5 no filler after stage", W'(rdValid), 0);
    expQ.delete();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    wrValid = 1'b0;
    wrData = '0;
    for (int i = 0; i < 3 * NB * BL; i++) mem[i] = {4{32'hDEAD_0000 + 32'(i)}};
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy == 0, "R1 busy in reset", W'(busy), 0);
    chk(done == 0, "R1 done in reset", W'(done), 0);
    chk(memReq == 0, "R1 memReq in reset", W'(memReq), 0);
    chk(rdValid == 0 && wrReady == 0, "R1 handshakes in reset", W'({rdValid, wrReady}), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && memReq == 0, "R1 idle after reset", W'({busy, done, memReq}), 0);
    @(posedge clk); #1;

    // write main region; inputs scrambled and a start pulsed mid-stage (R2, R9)
    readyMode = 1;
    startStage(1'b1, 0);
    for (int i = 0; i < N; i++) begin
      shadow[0][i] = pval(0, i, 16'h11);
      sendBeat(shadow[0][i]);
      if (i == 5) begin
        start = 1'b1;
        regionSel = 2'd2;
        writeMode = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1 && memWrite == 1'b1, "R9 start while busy ignored", W'({busy, memWrite}), 3);
        @(posedge clk); #1;
      end
    end
    waitDone();
    chk(wrReqCount == NB, "R3 write burst count", W'(wrReqCount), W'(NB));
    repeat (3) @(posedge clk);
    #1;
    chk(done == 1'b1, "R8 done held", W'(done), 1);

    // write aux region 1 with memory stalled (R7, R10)
    readyMode = 0;
    @(posedge clk); #1;
    startStage(1'b1, 1);
    for (int i = 0; i < N; i++) shadow[1][i] = pval(1, i, 16'h22);
    for (int i = 0; i < BL; i++) sendBeat(shadow[1][i]);
    repeat (3) @(negedge clk);
    chk(wrReady == 1'b0, "R7 wrReady low with burst waiting", W'(wrReady), 0);
    chk(memReq == 1'b1 && memWrite == 1'b1, "R10 write request held", W'({memReq, memWrite}), 3);
    chk(memAddr == AW'(NB), "R10 held address", W'(memAddr), W'(NB));
    @(posedge clk); #1;
    readyMode = 2;
    for (int i = BL; i < N; i++) sendBeat(shadow[1][i]);
    @(negedge clk);
    chk(wrReady == 1'b0, "R7 wrReady low after N accepted", W'(wrReady), 0);
    @(posedge clk); #1;
    waitDone();

    // write aux region 2 with throttled memory
    readyMode = 2;
    startStage(1'b1, 2);
    for (int i = 0; i < N; i++) begin
      shadow[2][i] = pval(2, i, 16'h33);
      sendBeat(shadow[2][i]);
    end
    waitDone();

    // reads
    readyMode = 1;
    readStage(0, 1);
    readyMode = 2;
    readStage(1, 2);

    // consumer stalled: prefetch must stop at FIFO capacity (R4)
    readyMode = 1;
    for (int i = 0; i < N; i++) expQ.push_back(shadow[2][i]);
    consMode = 0;
    startStage(1'b0, 2);
    repeat (40) @(posedge clk);
    #1;
    chk(rdReqCount == DEPTH / BL, "R4 prefetch limited by FIFO room", W'(rdReqCount), W'(DEPTH / BL));
    chk(rdValid == 1'b1, "R4 data ready before demand", W'(rdValid), 1);
    consMode = 1;
    waitDone();
    chk(expQ.size() == 0, "R5 stalled read delivered all", W'(expQ.size()), 0);
    expQ.delete();

    // region code 3 aliases the main region (R2)
    readStage(3, 2);

    finishRun();
  end

endmodule